// File: doc/BRIEF.md
# NAND Page Autoload Ping-Pong Reader

This block pulls one page of data out of a NAND flash device without processor involvement once it has been armed. Software issues the read command, then sets the arm condition (start bit set, select bit clear) before the address phase. The engine then watches the device's ready/busy line. On its first rising edge after arming, the engine runs back-to-back byte reads over a simple strobe/acknowledge data bus until a full page has been moved.

Every accepted byte is packed into one of two 16-byte banks, each organised as four 32-bit words. The same byte is copied to one of two ECC calculator ports, and a select bit picks which. When a bank fills, a DMA request is raised and the DMA engine drains that bank word by word through a single read port. Meanwhile the flash keeps filling the other bank. The flash side waits only when both banks are full.

Top module: `nand_autoload_pingpong`

## Requirements
- R1: While `rst` is high and on the cycle after it, `nand_re`, `dma_req`, `page_done`, `ecc_ham_stb` and `ecc_rs_stb` are 0 and `dma_rdata` is 0.
- R2: The arm condition is `cfg_start`=1 with `cfg_sel`=0. The engine arms only on a clock where this condition is true and was false on the previous clock. A condition that stays true after a page completes does not re-arm it.
- R3: An armed engine starts reading on the first clock where `nand_rb` is 1 after being 0 on the previous clock. `nand_re` is high from the next cycle. A ready/busy edge seen while not armed starts nothing.
- R4: A byte is accepted on every clock edge where `nand_re`, `nand_ack` and the arm condition are all 1.
- R5: On the cycle after a byte is accepted, `ecc_byte` holds that byte. Exactly one strobe pulses for one cycle: `ecc_ham_stb` when `cfg_ecc_rs`=0, and `ecc_rs_stb` when `cfg_ecc_rs`=1. Neither strobe pulses in any other cycle.
- R6: Byte k of a bank (k = 0..15) lands in word k/4 at bits 8*(k%4)+7 : 8*(k%4). The first byte of a word is therefore the least significant.
- R7: Banks fill in the order 0, 1, 0, 1, starting with bank 0. Draining follows the same order. `dma_req` is 1 exactly while the bank next in drain order is full.
- R8: A `dma_rd` pulse while `dma_req` is 1 places the next word of that bank on `dma_rdata` in the following cycle. After the bank's fourth word the bank becomes empty. A `dma_rd` pulse while `dma_req` is 0 changes nothing.
- R9: When the bank due to be written next is still full, `nand_re` stays 0 until DMA empties it. No stored word is overwritten.
- R10: On the cycle after the 512th byte is accepted, `page_done` is 1 for exactly one cycle. From then on `nand_re` stays 0 and the engine is disarmed.
- R11: When the arm condition goes false, no byte is accepted at that edge. From the next cycle `nand_re` and `dma_req` are 0, both banks are empty, and the byte count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start bit; clearing it aborts |
| cfg_sel | input | 1 | Select bit; must be 0 to arm |
| cfg_ecc_rs | input | 1 | 0 steers bytes to the Hamming port, 1 to the Reed-Solomon port |
| nand_rb | input | 1 | Flash ready/busy, 1 = ready |
| nand_re | output | 1 | Read strobe, byte requested |
| nand_ack | input | 1 | Flash has valid data on `nand_din` |
| nand_din | input | 8 | Flash data byte |
| ecc_byte | output | 8 | Byte presented to the ECC calculators |
| ecc_ham_stb | output | 1 | Byte valid for the Hamming calculator |
| ecc_rs_stb | output | 1 | Byte valid for the Reed-Solomon calculator |
| dma_rd | input | 1 | DMA reads one word |
| dma_req | output | 1 | A full bank awaits DMA |
| dma_rdata | output | 32 | Word returned for the last accepted DMA read |
| page_done | output | 1 | One-cycle pulse at end of page |

## Verification
The assertions assume that `nand_ack` matters only while `nand_re` is high. They also assume the arm inputs and `cfg_ecc_rs` are quasi-static register bits that change only between clocks. The bench drives every input once per cycle on the falling edge, so the design sees each value settled for a whole cycle. It does issue `dma_rd` freely, including while no request is pending, so the ignore rule of R8 is exercised. Acknowledge patterns and DMA rates come from an LFSR, which keeps the runs repeatable while producing stalls on both sides.

// File: rtl/nal_pkg.sv
package nal_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_READ = 2'd2
  } seq_state_e;
endpackage

// File: rtl/nal_sequencer.sv
module nal_sequencer #(
  parameter int PAGE_BYTES = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_lvl,
  input  logic rb,
  input  logic byte_take,
  output logic reading,
  output logic flush,
  output logic page_done
);
  import nal_pkg::*;

  localparam int CNT_W = $clog2(PAGE_BYTES);

  seq_state_e     state;
  logic           rb_q;
  logic           arm_q;
  logic [CNT_W-1:0] cnt;
  logic           last_byte;

  assign last_byte = (cnt == CNT_W'(PAGE_BYTES - 1));
  assign reading   = (state == SEQ_READ);
  assign flush     = ~arm_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      rb_q      <= 1'b0;
      arm_q     <= 1'b0;
      cnt       <= '0;
      page_done <= 1'b0;
    end else begin
      rb_q      <= rb;
      arm_q     <= arm_lvl;
      page_done <= 1'b0;
      if (!arm_lvl) begin
        state <= SEQ_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          SEQ_IDLE: if (!arm_q) state <= SEQ_WAIT;
          SEQ_WAIT: if (rb && !rb_q) state <= SEQ_READ;
          SEQ_READ: begin
            if (byte_take) begin
              if (last_byte) begin
                cnt       <= '0;
                page_done <= 1'b1;
                state     <= SEQ_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nal_ecc_tap.sv
module nal_ecc_tap #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              use_rs,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] ecc_byte,
  output logic              ham_stb,
  output logic              rs_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ecc_byte <= '0;
      ham_stb  <= 1'b0;
      rs_stb   <= 1'b0;
    end else begin
      ham_stb <= take & ~use_rs;
      rs_stb  <= take & use_rs;
      if (take) ecc_byte <= din;
    end
  end
endmodule

// File: rtl/nal_pingpong_buf.sv
module nal_pingpong_buf #(
  parameter int LANES = 4,
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 wr_en,
  input  logic [7:0]           wr_byte,
  output logic                 wr_full,
  input  logic                 dma_rd,
  output logic                 dma_req,
  output logic [8*LANES-1:0]   dma_rdata
);
  localparam int WORD_W     = 8 * LANES;
  localparam int BANK_BYTES = LANES * DEPTH;
  localparam int BI_W       = $clog2(BANK_BYTES);
  localparam int WI_W       = $clog2(DEPTH);
  localparam int LI_W       = $clog2(LANES);
  localparam int MEM_WORDS  = 2 * DEPTH;

  logic [WORD_W-1:0] mem [MEM_WORDS];

  logic              wr_bank;
  logic [BI_W-1:0]   wr_pos;
  logic [WORD_W-1:0] pack;
  logic [WORD_W-1:0] wr_word;
  logic [LI_W-1:0]   wr_lane;
  logic [WI_W-1:0]   wr_widx;
  logic              word_done;
  logic              bank_done;
  logic [1:0]        full;
  logic [1:0]        full_nx;
  logic              rd_bank;
  logic [WI_W-1:0]   rd_pos;
  logic              dma_take;
  logic              dma_last;

  assign wr_lane   = wr_pos[LI_W-1:0];
  assign wr_widx   = wr_pos[BI_W-1:LI_W];
  assign word_done = wr_en && (wr_lane == LI_W'(LANES - 1));
  assign bank_done = wr_en && (wr_pos == BI_W'(BANK_BYTES - 1));
  assign dma_take  = dma_rd && full[rd_bank] && !flush;
  assign dma_last  = dma_take && (rd_pos == WI_W'(DEPTH - 1));
  assign wr_full   = full[wr_bank];
  assign dma_req   = full[rd_bank];

  always_comb begin
    wr_word = pack;
    wr_word[WORD_W-8 +: 8] = wr_byte;
  end

  // bank flags: a bank is set by its last write and cleared by its last read
  for (genvar b = 0; b < 2; b++) begin : g_flag
    always_comb begin
      full_nx[b] = full[b];
      if (bank_done && (wr_bank == b[0])) full_nx[b] = 1'b1;
      if (dma_last && (rd_bank == b[0]))  full_nx[b] = 1'b0;
    end
  end

  // storage: plain synchronous write and registered read
  always_ff @(posedge clk) begin
    if (word_done) mem[{wr_bank, wr_widx}] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) dma_rdata <= '0;
    else if (dma_take) dma_rdata <= mem[{rd_bank, rd_pos}];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_bank <= 1'b0;
      wr_pos  <= '0;
      pack    <= '0;
      full    <= '0;
      rd_bank <= 1'b0;
      rd_pos  <= '0;
    end else begin
      full <= full_nx;
      if (wr_en) begin
        pack[wr_lane*8 +: 8] <= wr_byte;
        wr_pos <= wr_pos + 1'b1;
        if (bank_done) wr_bank <= ~wr_bank;
      end
      if (dma_take) begin
        rd_pos <= rd_pos + 1'b1;
        if (dma_last) rd_bank <= ~rd_bank;
      end
    end
  end
endmodule

// File: rtl/nand_autoload_pingpong.sv
module nand_autoload_pingpong #(
  parameter int PAGE_BYTES = 512,
  parameter int LANES      = 4,
  parameter int DEPTH      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_start,
  input  logic                 cfg_sel,
  input  logic                 cfg_ecc_rs,
  input  logic                 nand_rb,
  output logic                 nand_re,
  input  logic                 nand_ack,
  input  logic [7:0]           nand_din,
  output logic [7:0]           ecc_byte,
  output logic                 ecc_ham_stb,
  output logic                 ecc_rs_stb,
  input  logic                 dma_rd,
  output logic                 dma_req,
  output logic [8*LANES-1:0]   dma_rdata,
  output logic                 page_done
);
  logic arm_lvl;
  logic reading;
  logic flush;
  logic wr_full;
  logic byte_take;

  assign arm_lvl   = cfg_start & ~cfg_sel;
  assign nand_re   = reading & ~wr_full;
  assign byte_take = nand_re & nand_ack & arm_lvl;

  nal_sequencer #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .arm_lvl   (arm_lvl),
    .rb        (nand_rb),
    .byte_take (byte_take),
    .reading   (reading),
    .flush     (flush),
    .page_done (page_done)
  );

  nal_ecc_tap #(.BYTE_W(8)) u_ecc (
    .clk      (clk),
    .rst      (rst),
    .take     (byte_take),
    .use_rs   (cfg_ecc_rs),
    .din      (nand_din),
    .ecc_byte (ecc_byte),
    .ham_stb  (ecc_ham_stb),
    .rs_stb   (ecc_rs_stb)
  );

  nal_pingpong_buf #(.LANES(LANES), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .wr_en     (byte_take),
    .wr_byte   (nand_din),
    .wr_full   (wr_full),
    .dma_rd    (dma_rd),
    .dma_req   (dma_req),
    .dma_rdata (dma_rdata)
  );
endmodule

// File: rtl/nal_checker.sv
module nal_checker #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_start,
  input logic               cfg_sel,
  input logic               nand_re,
  input logic               nand_ack,
  input logic               ecc_ham_stb,
  input logic               ecc_rs_stb,
  input logic               dma_rd,
  input logic               dma_req,
  input logic [8*LANES-1:0] dma_rdata,
  input logic               page_done
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ecc_ham_stb && ecc_rs_stb));

  // R5
  strobe_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
    (nand_re && nand_ack && cfg_start && !cfg_sel) |=> (ecc_ham_stb || ecc_rs_stb));

  // R5
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(nand_re && nand_ack && cfg_start && !cfg_sel) |=> !(ecc_ham_stb || ecc_rs_stb));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    page_done |=> !page_done);

  // R10
  done_stops_reads_chk: assert property (@(posedge clk) disable iff (rst)
    page_done |-> !nand_re);

  // R11
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_start && !cfg_sel) |=> (!nand_re && !dma_req));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(dma_rd && dma_req) |=> $stable(dma_rdata));
endmodule

bind nand_autoload_pingpong nal_checker #(.LANES(LANES)) u_nal_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_start   (cfg_start),
  .cfg_sel     (cfg_sel),
  .nand_re     (nand_re),
  .nand_ack    (nand_ack),
  .ecc_ham_stb (ecc_ham_stb),
  .ecc_rs_stb  (ecc_rs_stb),
  .dma_rd      (dma_rd),
  .dma_req     (dma_req),
  .dma_rdata   (dma_rdata),
  .page_done   (page_done)
);

// File: tb/tb_nand_autoload_pingpong.sv
module tb_nand_autoload_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_start = 1'b0, cfg_sel = 1'b0, cfg_ecc_rs = 1'b0, nand_rb = 1'b0;
  logic nand_ack = 1'b0, dma_rd = 1'b0;
  logic [7:0] nand_din = 8'h00;
  logic nand_re, ecc_ham_stb, ecc_rs_stb, dma_req, page_done;
  logic [7:0] ecc_byte;
  logic [31:0] dma_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_autoload_pingpong dut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_sel(cfg_sel),
    .cfg_ecc_rs(cfg_ecc_rs), .nand_rb(nand_rb), .nand_re(nand_re),
    .nand_ack(nand_ack), .nand_din(nand_din), .ecc_byte(ecc_byte),
    .ecc_ham_stb(ecc_ham_stb), .ecc_rs_stb(ecc_rs_stb), .dma_rd(dma_rd),
    .dma_req(dma_req), .dma_rdata(dma_rdata), .page_done(page_done)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int done_cnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 waiting for ready, 2 reading
  int   m_state, m_wsel, m_rsel, m_bidx, m_bcnt, m_rword;
  bit   m_rbp, m_armp, m_done, m_ham, m_rs;
  bit   m_full [2];
  logic [31:0] m_buf [2][4];
  logic [7:0]  m_ecc;
  logic [31:0] m_rdata;
  bit   m_first_pending, m_first_due;
  bit   s_arm, s_xfer, s_drd;

  function automatic bit m_re();
    return (m_state == 2) && !m_full[m_wsel];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_wsel = 0; m_rsel = 0; m_bidx = 0; m_bcnt = 0; m_rword = 0;
      m_rbp = 0; m_armp = 0; m_done = 0; m_ham = 0; m_rs = 0;
      m_full[0] = 0; m_full[1] = 0; m_ecc = 0; m_rdata = 0;
    end else begin
      s_arm  = cfg_start && !cfg_sel;
      s_xfer = m_re() && nand_ack && s_arm;
      s_drd  = dma_rd && m_full[m_rsel];
      m_done = 0;
      m_ham  = s_xfer && !cfg_ecc_rs;
      m_rs   = s_xfer && cfg_ecc_rs;
      if (s_xfer) m_ecc = nand_din;
      if (!s_arm) begin
        m_state = 0; m_wsel = 0; m_rsel = 0; m_bidx = 0; m_bcnt = 0; m_rword = 0;
        m_full[0] = 0; m_full[1] = 0;
      end else begin
        if (s_drd) begin
          m_rdata = m_buf[m_rsel][m_rword];
          if (m_first_pending) begin m_first_pending = 0; m_first_due = 1; end
          m_rword++;
          if (m_rword == 4) begin m_full[m_rsel] = 0; m_rsel ^= 1; m_rword = 0; end
        end
        if (s_xfer) begin
          m_buf[m_wsel][m_bidx/4][8*(m_bidx%4) +: 8] = nand_din;
          m_bidx++; m_bcnt++;
          if (m_bidx == 16) begin m_full[m_wsel] = 1; m_wsel ^= 1; m_bidx = 0; end
          if (m_bcnt == 512) begin m_done = 1; m_state = 0; m_bcnt = 0; end
        end else if (m_state == 0 && !m_armp) m_state = 1;
        else if (m_state == 1 && nand_rb && !m_rbp) m_state = 2;
      end
      m_rbp  = nand_rb;
      m_armp = s_arm;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R4/R9 nand_re", 32'(nand_re), 32'(m_re()));
      chk("R7 dma_req", 32'(dma_req), 32'(m_full[m_rsel]));
      chk("R8 dma_rdata", dma_rdata, m_rdata);
      chk("R5 ecc_byte", 32'(ecc_byte), 32'(m_ecc));
      chk("R5 ham_stb", 32'(ecc_ham_stb), 32'(m_ham));
      chk("R5 rs_stb", 32'(ecc_rs_stb), 32'(m_rs));
      chk("R10 page_done", 32'(page_done), 32'(m_done));
      if (m_done) done_cnt++;
      if (m_first_due) begin
        chk("R6 first packed word", dma_rdata, 32'h0302_0100);
        m_first_due = 0;
      end
    end
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL R10 watchdog actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // stimulus generator for the handshakes
  logic [15:0] lfsr = 16'hACE1;
  bit ack_all = 1, din_index = 1, dma_on = 0, dma_slow = 0;
  always @(negedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    nand_ack <= ack_all ? 1'b1 : (lfsr[0] | lfsr[1]);
    dma_rd   <= dma_on && (dma_slow ? (lfsr[4:2] == 3'b000) : lfsr[3]);
    nand_din <= din_index ? m_bcnt[7:0] : lfsr[15:8];
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rb_edge();
    nand_rb = 1'b0; tick(2); nand_rb = 1'b1; tick(1);
  endtask

  task automatic wait_done(input int limit);
    int start = done_cnt;
    for (int i = 0; i < limit; i++) begin
      if (done_cnt != start) break;
      tick(1);
    end
  endtask

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 nand_re", 32'(nand_re), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    chk("R1 page_done", 32'(page_done), 0);
    chk("R1 strobes", 32'(ecc_ham_stb | ecc_rs_stb), 0);
    chk("R1 dma_rdata", dma_rdata, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 nand_re after release", 32'(nand_re), 0);

    // R3: ready edge while unarmed is ignored
    rb_edge(); tick(2);
    cfg_start = 1'b1; tick(5);
    chk("R3 no read without new edge", 32'(nand_re), 0);

    // page 1: index data, fast DMA, Hamming port
    m_first_pending = 1; dma_on = 1; dma_slow = 0; cfg_ecc_rs = 0;
    rb_edge();
    chk("R3 read begins after edge", 32'(nand_re), 1);
    wait_done(5000);
    tick(60);
    chk("R8 banks drained", 32'(dma_req), 0);

    // R2: condition held true does not re-arm
    rb_edge(); tick(10);
    chk("R2 no rearm while held", 32'(nand_re), 0);

    // page 2: random data and ack, slow DMA, Reed-Solomon port
    cfg_start = 1'b0; tick(2); cfg_start = 1'b1; tick(2);
    ack_all = 0; din_index = 0; dma_slow = 1; cfg_ecc_rs = 1;
    rb_edge();
    for (int i = 0; i < 3000; i++) begin
      if (m_full[0] && m_full[1] && m_state == 2) break;
      tick(1);
    end
    chk("R9 stall with both banks full", 32'(nand_re), 0);
    wait_done(20000);
    tick(400);
    chk("R7 drained after slow page", 32'(dma_req), 0);

    // R11: abort mid-page flushes
    cfg_start = 1'b0; tick(2); cfg_start = 1'b1; tick(2);
    dma_on = 0; ack_all = 1;
    rb_edge(); tick(40);
    chk("R11 banks filled before abort", 32'(dma_req), 1);
    cfg_start = 1'b0; tick(1);
    chk("R11 nand_re after abort", 32'(nand_re), 0);
    chk("R11 dma_req after abort", 32'(dma_req), 0);
    dma_on = 1; tick(20);
    chk("R11 banks stay empty", 32'(dma_req), 0);

    // R2: select bit set blocks arming
    cfg_sel = 1'b1; cfg_start = 1'b1; tick(3);
    rb_edge(); tick(5);
    chk("R2 select blocks arm", 32'(nand_re), 0);
    cfg_sel = 1'b0; tick(3);
    cfg_ecc_rs = 0; dma_slow = 0; din_index = 1;
    rb_edge();
    wait_done(5000);
    tick(60);
    chk("R10 no reads after page", 32'(nand_re), 0);
    chk("R10 pages completed", 32'(done_cnt), 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule